// File: doc/BRIEF.md
# Preemptive DMA Descriptor Sequencer

This block runs memory-to-memory transfer loops for four channels. Each channel's loop is described by a descriptor. The descriptors sit in a small local descriptor memory that lives outside the block. The block reads that memory through an asynchronous read port and updates it through a single-cycle write port.

A one-cycle strobe on a channel's request line marks that channel pending. When the block is idle, it takes the highest-numbered pending channel and copies its descriptor into a primary working register set. It then runs one minor loop on the address stage of a pipelined bus. Each access of the loop is a read/write pair: a read at the source address, then a write at the destination address. After each pair, both addresses move by signed per-access steps.

A second working register set lets a more urgent channel step in at a pair boundary. The urgent channel runs its whole minor loop. The interrupted channel then carries on from its saved registers, with no new descriptor read.

At the end of every minor loop, the updated addresses and iteration count go back to the channel's home slot. When the major loop ends, three things happen:
- Signed final adjustments replace the usual steps on the last pair.
- The iteration count is reloaded.
- A linked descriptor may be copied into the home slot.

Top module: `dma_desc_engine`

## Requirements
- R1: While reset is held and after it is released with no request, bus_valid, desc_wr_en and done are all 0.
- R2: A one-cycle strobe on req[c] marks channel c pending. When idle, the block starts the highest-numbered pending channel. It reads that channel's descriptor from slot c, where slot number equals channel number.
- R3: A minor loop issues n_acc read/write pairs. Each pair is a read (bus_write=0) at src_addr followed by a write (bus_write=1) at dst_addr. The descriptor is the packed struct desc_t with fields from most significant to least: sg_en, sg_slot, src_last, dst_last, iter_init, iter_now, n_acc, src_step, dst_step, src_addr, dst_addr.
- R4: After each pair that is not the final pair of a major loop, src_addr grows by the sign-extended 8-bit src_step and dst_addr by dst_step, both modulo 2^16.
- R5: After each minor loop, one write to the channel's home slot stores the updated addresses and iter_now minus one. All other fields are unchanged.
- R6: When iter_now is 1 at the end of a minor loop, the final pair adds src_last and dst_last in place of the steps. The written iter_now equals iter_init. done[c] is high for exactly the one cycle of that write.
- R7: On such a major completion with sg_en set, the home slot receives an exact copy of the descriptor at slot sg_slot, instead of the updated values.
- R8: After a pair completes mid-loop, three conditions allow preemption:
  - a pending channel has a higher number than the running primary channel;
  - preempt_ok of the running channel is 1;
  - the second register set is free.
  When all three hold, that channel runs its full minor loop and writes back. The primary then resumes at its next pair with no descriptor read.
- R9: With preempt_ok of the running channel at 0, its minor loop completes before any other channel starts.
- R10: A channel running from the second register set is never interrupted. Its pairs are contiguous on the bus.
- R11: While bus_valid is high and bus_ready is low, bus_addr and bus_write hold. A stalled bus changes only timing, not the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel service strobe |
| preempt_ok | input | NUM_CH | Per-channel enable allowing a running loop to be interrupted |
| desc_rd_addr | output | SLOT_W | Descriptor memory read slot |
| desc_rd_data | input | DESC_W | Descriptor read data, same cycle |
| desc_wr_en | output | 1 | Descriptor write strobe |
| desc_wr_addr | output | SLOT_W | Descriptor write slot |
| desc_wr_data | output | DESC_W | Descriptor write data |
| bus_valid | output | 1 | Address phase valid |
| bus_write | output | 1 | 1 for write access, 0 for read |
| bus_addr | output | ADDR_W | Address phase address |
| bus_ready | input | 1 | Bus accepts the current address phase |
| done | output | NUM_CH | One-cycle major loop completion pulse per channel |

## Verification
Some rules are checked on every cycle by properties in the RTL:
- address and direction hold through a stall;
- done is one-hot and only ever coincides with a write-back;
- the second set is only in use on top of a live primary;
- the second set is only ever loaded when the running channel allows preemption;
- a running second-set channel is never swapped out.

Other behaviour can only be shown by the bench's scenarios, because it depends on the exact order of accesses and write-backs. This covers the address arithmetic, final adjustments, count reload, linked descriptor copy, arbitration order, and the resume point after a preemption. The bench predicts those sequences from descriptor values it chose itself.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 8;
  localparam int CNT_W  = 4;
  localparam int ITER_W = 8;
  localparam int SLOT_W = 3;

  typedef struct packed {
    logic              sg_en;
    logic [SLOT_W-1:0] sg_slot;
    logic [ADDR_W-1:0] src_last;
    logic [ADDR_W-1:0] dst_last;
    logic [ITER_W-1:0] iter_init;
    logic [ITER_W-1:0] iter_now;
    logic [CNT_W-1:0]  n_acc;
    logic [OFF_W-1:0]  src_step;
    logic [OFF_W-1:0]  dst_step;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  // signed short step added to an address, wrapping modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a,
                                                  input logic [OFF_W-1:0]  o);
    return a + {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction
endpackage

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic              any_o,
  output logic [CH_W-1:0]   top_o
);
  logic [NUM_CH-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // fixed priority: highest-numbered pending channel wins
  always_comb begin
    top_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_q[i]) top_o = CH_W'(i);
    end
    any_o = |pend_q;
  end

  assert_top_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend_q[top_o]);
  assert_clr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));
  assert_clr_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |-> (|(clr_i & pend_q)));
endmodule

// File: rtl/dma_desc_set.sv
module dma_desc_set import dma_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  desc_t            load_desc_i,
  input  logic [CH_W-1:0]  load_ch_i,
  input  logic             step_i,
  input  logic             free_i,
  output desc_t            desc_o,
  output logic [CNT_W-1:0] rem_o,
  output logic [CH_W-1:0]  ch_o,
  output logic             vld_o
);
  desc_t            d_q, d_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic             vld_q, vld_d;
  logic             fin_pair;
  logic             en;

  assign fin_pair = (rem_q == CNT_W'(1)) && (d_q.iter_now == ITER_W'(1));
  assign en       = load_i | step_i | free_i;

  always_comb begin
    d_d   = d_q;
    rem_d = rem_q;
    ch_d  = ch_q;
    vld_d = vld_q;
    if (load_i) begin
      d_d   = load_desc_i;
      rem_d = load_desc_i.n_acc;
      ch_d  = load_ch_i;
      vld_d = 1'b1;
    end else if (step_i) begin
      if (fin_pair) begin
        d_d.src_addr = d_q.src_addr + d_q.src_last;
        d_d.dst_addr = d_q.dst_addr + d_q.dst_last;
      end else begin
        d_d.src_addr = addr_step(d_q.src_addr, d_q.src_step);
        d_d.dst_addr = addr_step(d_q.dst_addr, d_q.dst_step);
      end
      rem_d = rem_q - CNT_W'(1);
    end
    if (free_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= '0;
      rem_q <= '0;
      ch_q  <= '0;
      vld_q <= 1'b0;
    end else if (en) begin
      d_q   <= d_d;
      rem_q <= rem_d;
      ch_q  <= ch_d;
      vld_q <= vld_d;
    end
  end

  assign desc_o = d_q;
  assign rem_o  = rem_q;
  assign ch_o   = ch_q;
  assign vld_o  = vld_q;

  assert_step_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (vld_q && rem_q != '0));
  assert_load_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !vld_q);
endmodule

// File: rtl/dma_wb_fmt.sv
module dma_wb_fmt import dma_pkg::*; (
  input  desc_t cur_i,
  input  desc_t link_i,
  output desc_t wr_o,
  output logic  major_o
);
  desc_t upd;

  always_comb begin
    major_o = (cur_i.iter_now == ITER_W'(1));
    upd     = cur_i;
    upd.iter_now = major_o ? cur_i.iter_init : (cur_i.iter_now - ITER_W'(1));
    wr_o    = (major_o && cur_i.sg_en) ? link_i : upd;
  end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine import dma_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NSET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] preempt_ok,
  output logic [SLOT_W-1:0] desc_rd_addr,
  input  logic [DESC_W-1:0] desc_rd_data,
  output logic              desc_wr_en,
  output logic [SLOT_W-1:0] desc_wr_addr,
  output logic [DESC_W-1:0] desc_wr_data,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ready,
  output logic [NUM_CH-1:0] done
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WB} st_t;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  st_t             st_q, st_d;
  logic            act_q, act_d;     // running set: 0 primary, 1 secondary
  logic            fsec_q, fsec_d;   // set targeted by the next fetch
  logic [CH_W-1:0] fch_q, fch_d;     // channel targeted by the next fetch

  logic            any_pend;
  logic [CH_W-1:0] top_ch;
  logic [NUM_CH-1:0] clr;

  desc_t            sd   [NSET];
  logic [CNT_W-1:0] srem [NSET];
  logic [CH_W-1:0]  sch  [NSET];
  logic             svld [NSET];
  logic [NSET-1:0]  s_load, s_step, s_free;

  desc_t cur, wr_desc;
  logic  major;
  logic  pair_done, last_pair, preempt, ok_cur;

  dma_req_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk   (clk),
    .rst_n (rst_i),
    .req_i (req),
    .clr_i (clr),
    .any_o (any_pend),
    .top_o (top_ch)
  );

  for (genvar g = 0; g < NSET; g++) begin : g_set
    dma_desc_set #(.NUM_CH(NUM_CH)) u_set (
      .clk         (clk),
      .rst_n       (rst_i),
      .load_i      (s_load[g]),
      .load_desc_i (desc_t'(desc_rd_data)),
      .load_ch_i   (fch_q),
      .step_i      (s_step[g]),
      .free_i      (s_free[g]),
      .desc_o      (sd[g]),
      .rem_o       (srem[g]),
      .ch_o        (sch[g]),
      .vld_o       (svld[g])
    );
    assign s_load[g] = (st_q == S_FETCH) && (fsec_q == g[0]);
    assign s_step[g] = pair_done && (act_q == g[0]);
    assign s_free[g] = (st_q == S_WB) && (act_q == g[0]);
  end

  assign cur = sd[act_q];

  dma_wb_fmt u_fmt (
    .cur_i   (cur),
    .link_i  (desc_t'(desc_rd_data)),
    .wr_o    (wr_desc),
    .major_o (major)
  );

  assign pair_done = (st_q == S_WR) && bus_ready;
  assign last_pair = (srem[act_q] == CNT_W'(1));
  assign ok_cur    = preempt_ok[sch[0]];
  assign preempt   = !act_q && !svld[1] && any_pend && (top_ch > sch[0]) && ok_cur;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    fsec_d = fsec_q;
    fch_d  = fch_q;
    case (st_q)
      S_IDLE: begin
        if (any_pend) begin
          st_d   = S_FETCH;
          fch_d  = top_ch;
          fsec_d = 1'b0;
        end
      end
      S_FETCH: begin
        st_d  = S_RD;
        act_d = fsec_q;
      end
      S_RD: begin
        if (bus_ready) st_d = S_WR;
      end
      S_WR: begin
        if (bus_ready) begin
          if (last_pair) begin
            st_d = S_WB;
          end else if (preempt) begin
            st_d   = S_FETCH;
            fch_d  = top_ch;
            fsec_d = 1'b1;
          end else begin
            st_d = S_RD;
          end
        end
      end
      S_WB: begin
        if (act_q) begin
          act_d = 1'b0;
          st_d  = S_RD;
        end else begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= S_IDLE;
      act_q  <= 1'b0;
      fsec_q <= 1'b0;
      fch_q  <= '0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      fsec_q <= fsec_d;
      fch_q  <= fch_d;
    end
  end

  assign clr = (st_q == S_FETCH) ? (NUM_CH'(1) << fch_q) : '0;

  assign desc_rd_addr = (st_q == S_WB) ? cur.sg_slot : SLOT_W'(fch_q);
  assign desc_wr_en   = (st_q == S_WB);
  assign desc_wr_addr = SLOT_W'(sch[act_q]);
  assign desc_wr_data = wr_desc;

  assign bus_valid = (st_q == S_RD) || (st_q == S_WR);
  assign bus_write = (st_q == S_WR);
  assign bus_addr  = (st_q == S_WR) ? cur.dst_addr : cur.src_addr;

  assign done = ((st_q == S_WB) && major) ? (NUM_CH'(1) << sch[act_q]) : '0;

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));
  assert_done_onehot_R6: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(done));
  assert_done_with_wb_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (|done) |-> desc_wr_en);
  assert_wb_off_bus_R5: assert property (@(posedge clk) disable iff (!rst_i)
    desc_wr_en |-> !bus_valid);
  assert_sec_on_prim_R8: assert property (@(posedge clk) disable iff (!rst_i)
    svld[1] |-> svld[0]);
  assert_preempt_gate_R9: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(svld[1]) |-> $past(ok_cur, 2));
  assert_sec_kept_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (svld[1] && st_q != S_WB) |=> (svld[1] && $stable(sch[1])));
endmodule

// File: tb/tb_dma_desc_engine.sv
module tb_dma_desc_engine;
  import dma_pkg::*;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]    req = '0;
  logic [NCH-1:0]    pok = '0;
  logic              bus_ready = 1'b1;
  logic              stall = 1'b0;
  logic [7:0]        lfsr = 8'hA5;
  logic [SLOT_W-1:0] desc_rd_addr, desc_wr_addr;
  logic [DESC_W-1:0] desc_rd_data, desc_wr_data;
  logic              desc_wr_en, bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [NCH-1:0]    done;

  desc_t mem [8];
  assign desc_rd_data = mem[desc_rd_addr];
  always @(posedge clk) if (desc_wr_en) mem[desc_wr_addr] <= desc_t'(desc_wr_data);

  dma_desc_engine #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .preempt_ok(pok),
    .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr), .desc_wr_data(desc_wr_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_ready(bus_ready), .done(done));

  int total = 0, bad = 0, stalls = 0;
  bit finished = 0;
  logic [16:0]       act_bus [512], exp_bus [512];
  logic [SLOT_W-1:0] act_ws [64], exp_ws [64];
  desc_t             act_wd [64], exp_wd [64];
  int n_act = 0, n_exp = 0, n_aw = 0, n_ew = 0;
  int dcnt [NCH];

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid && !bus_ready) stalls++;
      if (bus_valid && bus_ready && n_act < 512) begin
        act_bus[n_act] = {bus_write, bus_addr};
        n_act++;
      end
      if (desc_wr_en && n_aw < 64) begin
        act_ws[n_aw] = desc_wr_addr;
        act_wd[n_aw] = desc_t'(desc_wr_data);
        n_aw++;
      end
      for (int c = 0; c < NCH; c++) if (done[c]) dcnt[c]++;
    end
  end

  task automatic chk(bit ok, string rq, string what, logic [127:0] a, logic [127:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, a, e);
    end
  endtask

  function automatic desc_t mk(logic [15:0] sa, logic [15:0] da, logic [7:0] so,
                               logic [7:0] dof, logic [3:0] n, logic [7:0] ci,
                               logic [7:0] bi, logic [15:0] sl, logic [15:0] dl,
                               logic sg, logic [2:0] slot);
    desc_t d;
    d.sg_en = sg; d.sg_slot = slot; d.src_last = sl; d.dst_last = dl;
    d.iter_init = bi; d.iter_now = ci; d.n_acc = n; d.src_step = so;
    d.dst_step = dof; d.src_addr = sa; d.dst_addr = da;
    return d;
  endfunction

  task automatic exp_pairs(inout desc_t d, inout int rem, input int n);
    for (int i = 0; i < n; i++) begin
      exp_bus[n_exp] = {1'b0, d.src_addr}; n_exp++;
      exp_bus[n_exp] = {1'b1, d.dst_addr}; n_exp++;
      if (rem == 1 && d.iter_now == 8'd1) begin
        d.src_addr = d.src_addr + d.src_last;
        d.dst_addr = d.dst_addr + d.dst_last;
      end else begin
        d.src_addr = d.src_addr + {{8{d.src_step[7]}}, d.src_step};
        d.dst_addr = d.dst_addr + {{8{d.dst_step[7]}}, d.dst_step};
      end
      rem--;
    end
  endtask

  function automatic desc_t after_wb(desc_t d);
    if (d.iter_now == 8'd1) d.iter_now = d.iter_init;
    else d.iter_now = d.iter_now - 8'd1;
    return d;
  endfunction

  task automatic exp_wb(logic [2:0] slot, desc_t v);
    exp_ws[n_ew] = slot; exp_wd[n_ew] = v; n_ew++;
  endtask

  task automatic clear_logs();
    n_act = 0; n_exp = 0; n_aw = 0; n_ew = 0;
  endtask

  task automatic compare(string rq);
    chk(n_act == n_exp, rq, "bus access count", n_act, n_exp);
    for (int i = 0; i < n_act && i < n_exp; i++)
      chk(act_bus[i] == exp_bus[i], rq, "bus access", act_bus[i], exp_bus[i]);
    chk(n_aw == n_ew, rq, "write-back count", n_aw, n_ew);
    for (int i = 0; i < n_aw && i < n_ew; i++) begin
      chk(act_ws[i] == exp_ws[i], rq, "write-back slot", act_ws[i], exp_ws[i]);
      chk(act_wd[i] == exp_wd[i], rq, "write-back data", act_wd[i], exp_wd[i]);
    end
    clear_logs();
  endtask

  task automatic pulse_req(logic [NCH-1:0] m);
    @(posedge clk); #1 req = m;
    @(posedge clk); #1 req = '0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (!bus_valid && !desc_wr_en) q++; else q = 0;
    end
  endtask

  task automatic wait_first_read();
    do @(negedge clk); while (!(bus_valid && !bus_write));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    desc_t d0, d1, d2, d3, d5;
    int r0, r1, r3, r5;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    for (int c = 0; c < NCH; c++) dcnt[c] = 0;

    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    chk(!bus_valid && !desc_wr_en && done == '0, "R1", "outputs in reset",
        {bus_valid, desc_wr_en, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(!bus_valid && !desc_wr_en && done == '0, "R1", "outputs after reset",
        {bus_valid, desc_wr_en, done}, 0);

    // R3 R4 R5 R6 R11: one channel, two minor loops, stalled bus
    stall = 1'b1;
    d1 = mk(16'h2000, 16'h2800, 8'd4, 8'hFE, 4'd3, 8'd2, 8'd2, 16'hFFE8, 16'h0010, 1'b0, 3'd0);
    mem[1] = d1;
    pulse_req(4'b0010); wait_quiet();
    r1 = 3; exp_pairs(d1, r1, 3); exp_wb(3'd1, after_wb(d1)); d1 = after_wb(d1);
    compare("R3");
    chk(dcnt[1] == 0, "R5", "no done mid major loop", dcnt[1], 0);
    pulse_req(4'b0010); wait_quiet();
    r1 = 3; exp_pairs(d1, r1, 3); exp_wb(3'd1, after_wb(d1));
    compare("R6");
    chk(dcnt[1] == 1, "R6", "done pulse count", dcnt[1], 1);
    chk(stalls > 0, "R11", "bus stalls seen", stalls, 1);
    stall = 1'b0;

    // R2: three simultaneous requests, highest number first
    pok = '0;
    d0 = mk(16'h1000, 16'h1800, 8'd1, 8'd1, 4'd2, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    d1 = mk(16'h2000, 16'h2800, 8'd2, 8'd2, 4'd2, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    d2 = mk(16'h3000, 16'h3800, 8'd3, 8'd3, 4'd2, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[0] = d0; mem[1] = d1; mem[2] = d2;
    pulse_req(4'b0111); wait_quiet();
    r0 = 2; exp_pairs(d2, r0, 2); exp_wb(3'd2, after_wb(d2));
    r0 = 2; exp_pairs(d1, r0, 2); exp_wb(3'd1, after_wb(d1));
    r0 = 2; exp_pairs(d0, r0, 2); exp_wb(3'd0, after_wb(d0));
    compare("R2");

    // R7: major completion with linked descriptor copy
    d0 = mk(16'h1000, 16'h1100, 8'd2, 8'd2, 4'd2, 8'd1, 8'd3, 16'h0100, 16'h0200, 1'b1, 3'd5);
    d5 = mk(16'h5000, 16'h5800, 8'd1, 8'hFF, 4'd3, 8'd4, 8'd4, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[0] = d0; mem[5] = d5;
    for (int c = 0; c < NCH; c++) dcnt[c] = 0;
    pulse_req(4'b0001); wait_quiet();
    r0 = 2; exp_pairs(d0, r0, 2); exp_wb(3'd0, d5);
    compare("R7");
    chk(dcnt[0] == 1, "R7", "done on linked completion", dcnt[0], 1);
    pulse_req(4'b0001); wait_quiet();
    r5 = 3; exp_pairs(d5, r5, 3); exp_wb(3'd0, after_wb(d5));
    compare("R7");

    // R8: preemption at a pair boundary, then resume
    pok = 4'b0010;
    d1 = mk(16'h2000, 16'h2800, 8'd4, 8'd4, 4'd6, 8'd3, 8'd3, 16'h0, 16'h0, 1'b0, 3'd0);
    d3 = mk(16'h4000, 16'h4800, 8'd2, 8'd2, 4'd2, 8'd3, 8'd3, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[1] = d1; mem[3] = d3;
    pulse_req(4'b0010); wait_first_read(); pulse_req(4'b1000); wait_quiet();
    r1 = 6; r3 = 2;
    exp_pairs(d1, r1, 2);
    exp_pairs(d3, r3, 2); exp_wb(3'd3, after_wb(d3));
    exp_pairs(d1, r1, 4); exp_wb(3'd1, after_wb(d1));
    compare("R8");

    // R9: same traffic, preemption disabled
    pok = 4'b0000;
    d1 = mk(16'h2000, 16'h2800, 8'd4, 8'd4, 4'd6, 8'd3, 8'd3, 16'h0, 16'h0, 1'b0, 3'd0);
    d3 = mk(16'h4000, 16'h4800, 8'd2, 8'd2, 4'd2, 8'd3, 8'd3, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[1] = d1; mem[3] = d3;
    pulse_req(4'b0010); wait_first_read(); pulse_req(4'b1000); wait_quiet();
    r1 = 6; r3 = 2;
    exp_pairs(d1, r1, 6); exp_wb(3'd1, after_wb(d1));
    exp_pairs(d3, r3, 2); exp_wb(3'd3, after_wb(d3));
    compare("R9");

    // R10: a preempting channel is not itself interrupted
    pok = 4'b1111;
    mem[0] = mk(16'h1000, 16'h1800, 8'd1, 8'd1, 4'd8, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[2] = mk(16'h3000, 16'h3800, 8'd1, 8'd1, 4'd4, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    mem[3] = mk(16'h4000, 16'h4800, 8'd1, 8'd1, 4'd2, 8'd5, 8'd5, 16'h0, 16'h0, 1'b0, 3'd0);
    pulse_req(4'b0001); wait_first_read(); pulse_req(4'b0100);
    do @(negedge clk); while (!(bus_valid && bus_addr[15:12] == 4'h3));
    pulse_req(4'b1000); wait_quiet();
    begin
      int f3 = -1, l3 = -1, c1 = 0, c3 = 0, c4 = 0, f4 = -1;
      for (int i = 0; i < n_act; i++) begin
        case (act_bus[i][15:12])
          4'h1: c1++;
          4'h3: begin c3++; if (f3 < 0) f3 = i; l3 = i; end
          4'h4: begin c4++; if (f4 < 0) f4 = i; end
          default: ;
        endcase
      end
      chk(c1 == 16, "R10", "primary access count", c1, 16);
      chk(c3 == 8, "R10", "second-set access count", c3, 8);
      chk(c4 == 4, "R10", "later channel access count", c4, 4);
      chk(l3 - f3 + 1 == 8, "R10", "second-set accesses contiguous", l3 - f3 + 1, 8);
      chk(f4 > l3, "R10", "later channel after second set", f4, l3 + 1);
      chk(n_aw == 3, "R10", "write-back count", n_aw, 3);
    end
    clear_logs();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule